// File: doc/BRIEF.md
# UART Automatic RTS/CTS Flow Controller

This block runs hardware handshake flow control for one UART channel. On the receive side it compares the receive FIFO fill count with a trigger level chosen from four. It raises a threshold interrupt request when the count reaches that level. It drives the active-low RTS pin with hysteresis that spans the neighbouring trigger levels. When automatic RTS is off, the pin is a general-purpose output that mirrors a register bit.

On the transmit side the block passes the active-low CTS input through a synchronizer. It grants the transmitter permission to begin each new character. A CTS deassertion never cuts a character short; only the next start is held back.

The RTS side is one state machine with three states. RTS_GPO means automatic RTS is off and the pin follows the manual bit. RTS_FLOW_ON means automatic mode with the pin asserted. RTS_FLOW_OFF means automatic mode with the pin deasserted because the FIFO is too full. Its transitions are:
- GPO to FLOW_ON when automatic RTS is enabled.
- FLOW_ON to FLOW_OFF when the count reaches the stop level.
- FLOW_OFF to FLOW_ON when the count falls to the resume level.
- Either flow state back to GPO when automatic RTS is disabled.

The CTS side is one state machine with three states: TX_READY, TX_SENDING and TX_HELD. Its transitions are:
- READY to SENDING on a start pulse.
- READY to HELD when automatic CTS is on and the synchronized CTS reads deasserted.
- SENDING to HELD or READY on the done pulse, depending on CTS.
- HELD to READY once CTS reads asserted or automatic CTS is switched off.

Top module: `hwflow_ctrl`

## Requirements
- R1: After reset, both automatic modes are treated as off, `rx_irq` is 0, `tx_allow` is 1, and `rts_n` equals the inverse of `rts_req`.
- R2: With `auto_rts_en` low, `rts_n` is the inverse of `rts_req` (general-purpose output) whatever the FIFO count.
- R3: `trig_sel` 0,1,2,3 selects trigger levels 1,4,8,14. With `auto_rts_en` high, `rx_irq` goes to 1 one clock after `rx_count` is at or above the trigger level. It returns to 0 one clock after the count is below it. With `auto_rts_en` low it stays 0.
- R4: In automatic mode with `rts_req` high, `rts_n` goes to 1 one clock after `rx_count` reaches the stop level. The stop level is 4, 8, 14 or 16 for `trig_sel` 0..3.
- R5: After such a deassertion, `rts_n` stays 1 until `rx_count` is at or below the resume level. The resume level is 0, 0, 3 or 7 for `trig_sel` 0..3. One clock later `rts_n` returns to 0.
- R6: In automatic mode `rts_n` is 1 whenever `rts_req` is 0.
- R7: With `auto_cts_en` low, `cts_n` has no effect and `tx_allow` is 1 whenever no character is in progress.
- R8: With `auto_cts_en` high and no character in progress, `tx_allow` reflects the inverse of `cts_n` three clocks after a change. The delay is two synchronizer flops plus the state register.
- R9: A character runs from a `tx_start` pulse to a `tx_done` pulse, and `tx_allow` is 0 throughout. A CTS deassertion during it takes effect only at `tx_done`, after which the next start is held off.
- R10: Dropping `auto_cts_en` while the transmitter is held sets `tx_allow` to 1 in the same cycle, with no clock edge needed.
- R11: `tx_start` is only pulsed while `tx_allow` is 1, and `tx_done` only while a character is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_rts_en | input | 1 | Enable automatic RTS control |
| auto_cts_en | input | 1 | Enable automatic CTS control |
| trig_sel | input | 2 | Receive trigger level select (1,4,8,14) |
| rx_count | input | 5 | Receive FIFO fill count, 0..16 |
| rts_req | input | 1 | Manual RTS bit, 1 requests RTS asserted |
| cts_n | input | 1 | Active-low clear-to-send pin, asynchronous |
| tx_start | input | 1 | Transmitter begins a character (pulse) |
| tx_done | input | 1 | Transmitter finished a character (pulse) |
| rts_n | output | 1 | Active-low request-to-send pin |
| rx_irq | output | 1 | Receive threshold interrupt request |
| tx_allow | output | 1 | Transmitter may begin a new character |

## Verification
The checker takes for granted that the transmitter obeys the handshake. It assumes `tx_start` arrives only while `tx_allow` is high and `tx_done` only after a start. It also assumes the FIFO count never exceeds the depth. The directed tasks drive start and done as single-cycle pulses in the order a real shifter would produce them. They keep `rx_count` within 0..16, and they change `cts_n` only on falling clock edges, so the synchronizer latency can be counted exactly.

// File: rtl/hwflow_pkg.sv
package hwflow_pkg;

    typedef enum logic [1:0] {
        RTS_GPO      = 2'd0,
        RTS_FLOW_ON  = 2'd1,
        RTS_FLOW_OFF = 2'd2
    } rts_state_t;

    typedef enum logic [1:0] {
        TX_READY   = 2'd0,
        TX_SENDING = 2'd1,
        TX_HELD    = 2'd2
    } tx_state_t;

endpackage

// File: rtl/hwflow_thresh.sv
module hwflow_thresh #(
    parameter int DEPTH = 16,
    parameter int LVL0  = 1,
    parameter int LVL1  = 4,
    parameter int LVL2  = 8,
    parameter int LVL3  = 14,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [1:0]       trig_sel,
    output logic [CNT_W-1:0] trig_lvl,
    output logic [CNT_W-1:0] stop_lvl,
    output logic [CNT_W-1:0] resume_lvl
);

    // Hysteresis window: stop at the next level up, resume below the next level down.
    always_comb begin
        unique case (trig_sel)
            2'd0: begin
                trig_lvl   = CNT_W'(LVL0);
                stop_lvl   = CNT_W'(LVL1);
                resume_lvl = '0;
            end
            2'd1: begin
                trig_lvl   = CNT_W'(LVL1);
                stop_lvl   = CNT_W'(LVL2);
                resume_lvl = CNT_W'(LVL0 - 1);
            end
            2'd2: begin
                trig_lvl   = CNT_W'(LVL2);
                stop_lvl   = CNT_W'(LVL3);
                resume_lvl = CNT_W'(LVL1 - 1);
            end
            default: begin
                trig_lvl   = CNT_W'(LVL3);
                stop_lvl   = CNT_W'(DEPTH);
                resume_lvl = CNT_W'(LVL2 - 1);
            end
        endcase
    end

endmodule

// File: rtl/hwflow_rts_fsm.sv
module hwflow_rts_fsm
    import hwflow_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             rts_req,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] trig_lvl,
    input  logic [CNT_W-1:0] stop_lvl,
    input  logic [CNT_W-1:0] resume_lvl,
    output logic             rts_n,
    output logic             rx_irq
);

    rts_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RTS_GPO: begin
                if (auto_en) state_d = RTS_FLOW_ON;
            end
            RTS_FLOW_ON: begin
                if (!auto_en)                  state_d = RTS_GPO;
                else if (rx_count >= stop_lvl) state_d = RTS_FLOW_OFF;
            end
            RTS_FLOW_OFF: begin
                if (!auto_en)                     state_d = RTS_GPO;
                else if (rx_count <= resume_lvl)  state_d = RTS_FLOW_ON;
            end
            default: state_d = RTS_GPO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RTS_GPO;
        else        state_q <= state_d;
    end

    // Pin level: manual bit gates every mode; flow-off forces deassertion.
    always_comb begin
        unique case (state_q)
            RTS_GPO:      rts_n = !rts_req;
            RTS_FLOW_ON:  rts_n = !rts_req;
            RTS_FLOW_OFF: rts_n = 1'b1;
            default:      rts_n = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_irq <= 1'b0;
        else        rx_irq <= auto_en && (rx_count >= trig_lvl);
    end

endmodule

// File: rtl/hwflow_cts_gate.sv
module hwflow_cts_gate
    import hwflow_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic cts_n,
    input  logic tx_start,
    input  logic tx_done,
    output logic cts_hi,
    output logic tx_allow
);

    // CTS synchronizer; resets to the deasserted level.
    generate
        if (SYNC_STAGES < 2) begin : g_sync1
            logic sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= 1'b1;
                else        sync_q <= cts_n;
            end
            assign cts_hi = sync_q;
        end else begin : g_syncn
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], cts_n};
            end
            assign cts_hi = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    tx_state_t state_q, state_d;
    logic      hold_now;

    assign hold_now = auto_en && cts_hi;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_READY: begin
                if (tx_start)      state_d = TX_SENDING;
                else if (hold_now) state_d = TX_HELD;
            end
            TX_SENDING: begin
                if (tx_done) state_d = hold_now ? TX_HELD : TX_READY;
            end
            TX_HELD: begin
                if (!hold_now) state_d = TX_READY;
            end
            default: state_d = TX_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_READY;
        else        state_q <= state_d;
    end

    // Permission: switching auto-CTS off frees a held transmitter at once.
    always_comb begin
        unique case (state_q)
            TX_READY:   tx_allow = 1'b1;
            TX_SENDING: tx_allow = 1'b0;
            TX_HELD:    tx_allow = !auto_en;
            default:    tx_allow = 1'b0;
        endcase
    end

endmodule

// File: rtl/hwflow_ctrl.sv
module hwflow_ctrl #(
    parameter int DEPTH       = 16,
    parameter int LVL0        = 1,
    parameter int LVL1        = 4,
    parameter int LVL2        = 8,
    parameter int LVL3        = 14,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rts_req,
    input  logic             cts_n,
    input  logic             tx_start,
    input  logic             tx_done,
    output logic             rts_n,
    output logic             rx_irq,
    output logic             tx_allow
);

    logic [CNT_W-1:0] trig_lvl, stop_lvl, resume_lvl;
    logic             cts_hi;

    hwflow_thresh #(
        .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
    ) u_thresh (
        .trig_sel   (trig_sel),
        .trig_lvl   (trig_lvl),
        .stop_lvl   (stop_lvl),
        .resume_lvl (resume_lvl)
    );

    hwflow_rts_fsm #(.CNT_W(CNT_W)) u_rts (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_en    (auto_rts_en),
        .rts_req    (rts_req),
        .rx_count   (rx_count),
        .trig_lvl   (trig_lvl),
        .stop_lvl   (stop_lvl),
        .resume_lvl (resume_lvl),
        .rts_n      (rts_n),
        .rx_irq     (rx_irq)
    );

    hwflow_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (auto_cts_en),
        .cts_n    (cts_n),
        .tx_start (tx_start),
        .tx_done  (tx_done),
        .cts_hi   (cts_hi),
        .tx_allow (tx_allow)
    );

endmodule

// File: rtl/hwflow_ctrl_chk.sv
module hwflow_ctrl_chk #(
    parameter int DEPTH = 16,
    parameter int LVL0  = 1,
    parameter int LVL1  = 4,
    parameter int LVL2  = 8,
    parameter int LVL3  = 14,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             auto_rts_en,
    input logic             auto_cts_en,
    input logic [1:0]       trig_sel,
    input logic [CNT_W-1:0] rx_count,
    input logic             rts_req,
    input logic             tx_start,
    input logic             tx_done,
    input logic             cts_hi,
    input logic             rts_n,
    input logic             rx_irq,
    input logic             tx_allow
);

    logic [CNT_W-1:0] exp_trig, exp_stop;
    logic             over_trig, over_stop;

    always_comb begin
        case (trig_sel)
            2'd0:    begin exp_trig = CNT_W'(LVL0); exp_stop = CNT_W'(LVL1);  end
            2'd1:    begin exp_trig = CNT_W'(LVL1); exp_stop = CNT_W'(LVL2);  end
            2'd2:    begin exp_trig = CNT_W'(LVL2); exp_stop = CNT_W'(LVL3);  end
            default: begin exp_trig = CNT_W'(LVL3); exp_stop = CNT_W'(DEPTH); end
        endcase
    end

    assign over_trig = rx_count >= exp_trig;
    assign over_stop = rx_count >= exp_stop;

    AST_START_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> tx_allow) else $error("tx_start while not allowed"); // R11

    AST_DONE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !tx_allow) else $error("tx_done with no character"); // R11

    AST_GPO_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_rts_en && $past(!auto_rts_en)) |-> (rts_n == !rts_req)) else $error("gpo"); // R2

    AST_RTS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && !rts_req) |-> rts_n) else $error("gated"); // R6

    AST_RTS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && $past(auto_rts_en) && $past(auto_rts_en, 2) && $past(over_stop))
        |-> rts_n) else $error("stop level"); // R4

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(auto_rts_en) && $past(over_trig)) |-> rx_irq) else $error("irq set"); // R3

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(auto_rts_en) || !$past(over_trig)) |-> !rx_irq) else $error("irq clear"); // R3

    AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts_en && $past(auto_cts_en) && $past(cts_hi) && !$past(tx_start))
        |-> !tx_allow) else $error("cts hold"); // R8

    AST_CTS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_cts_en && $past(!auto_cts_en) && $past(tx_allow) && !$past(tx_start))
        |-> tx_allow) else $error("cts ignored"); // R7

endmodule

bind hwflow_ctrl hwflow_ctrl_chk #(
    .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_rts_en (auto_rts_en),
    .auto_cts_en (auto_cts_en),
    .trig_sel    (trig_sel),
    .rx_count    (rx_count),
    .rts_req     (rts_req),
    .tx_start    (tx_start),
    .tx_done     (tx_done),
    .cts_hi      (cts_hi),
    .rts_n       (rts_n),
    .rx_irq      (rx_irq),
    .tx_allow    (tx_allow)
);

// File: tb/hwflow_ctrl_test.sv
`timescale 1ns/1ps
module hwflow_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_rts_en = 1'b0, auto_cts_en = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic [4:0] rx_count = '0;
    logic       rts_req = 1'b0, cts_n = 1'b0, tx_start = 1'b0, tx_done = 1'b0;
    logic       rts_n, rx_irq, tx_allow;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hwflow_ctrl uut (
        .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
        .trig_sel(trig_sel), .rx_count(rx_count), .rts_req(rts_req), .cts_n(cts_n),
        .tx_start(tx_start), .tx_done(tx_done), .rts_n(rts_n), .rx_irq(rx_irq),
        .tx_allow(tx_allow)
    );

    task automatic expect_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        tx_start = 1'b1; step(1); tx_start = 1'b0;
    endtask

    task automatic pulse_done();
        tx_done = 1'b1; step(1); tx_done = 1'b0;
    endtask

    task automatic t_reset();
        expect_bit(rts_n, 1'b1, "R1 rts_n after reset");
        expect_bit(rx_irq, 1'b0, "R1 rx_irq after reset");
        expect_bit(tx_allow, 1'b1, "R1 tx_allow after reset");
    endtask

    task automatic t_gpo();
        auto_rts_en = 1'b0; rx_count = 5'd16;
        rts_req = 1'b1; step(1);
        expect_bit(rts_n, 1'b0, "R2 gpo follows req=1 at full count");
        expect_bit(rx_irq, 1'b0, "R3 no irq with auto-RTS off");
        rts_req = 1'b0; step(1);
        expect_bit(rts_n, 1'b1, "R2 gpo follows req=0");
        rx_count = 5'd0;
    endtask

    task automatic t_hyst(input logic [1:0] sel, input int trig, input int stop, input int resume);
        trig_sel = sel; rts_req = 1'b1; rx_count = 5'd0; auto_rts_en = 1'b1; step(2);
        expect_bit(rts_n, 1'b0, "R4 rts asserted when empty");
        rx_count = 5'(trig - 1); step(1);
        expect_bit(rx_irq, 1'b0, "R3 no irq below trigger");
        rx_count = 5'(trig); step(1);
        expect_bit(rx_irq, 1'b1, "R3 irq at trigger");
        expect_bit(rts_n, 1'b0, "R4 rts still asserted at trigger");
        rx_count = 5'(stop - 1); step(1);
        expect_bit(rts_n, 1'b0, "R4 rts asserted below stop");
        rx_count = 5'(stop); step(1);
        expect_bit(rts_n, 1'b1, "R4 rts deasserted at stop");
        rx_count = 5'(resume + 1); step(1);
        expect_bit(rts_n, 1'b1, "R5 rts held above resume");
        rx_count = 5'(resume); step(1);
        expect_bit(rts_n, 1'b0, "R5 rts reasserted at resume");
        rx_count = 5'(trig - 1); step(1);
        expect_bit(rx_irq, 1'b0, "R3 irq cleared below trigger");
        auto_rts_en = 1'b0; rx_count = 5'd0; step(1);
    endtask

    task automatic t_gate();
        auto_rts_en = 1'b1; rx_count = 5'd0; rts_req = 1'b0; step(2);
        expect_bit(rts_n, 1'b1, "R6 manual bit low keeps rts deasserted");
        rts_req = 1'b1; step(1);
        expect_bit(rts_n, 1'b0, "R6 manual bit high lets auto assert");
        auto_rts_en = 1'b0; rts_req = 1'b0; step(1);
    endtask

    task automatic t_cts_off();
        auto_cts_en = 1'b0; cts_n = 1'b1; step(5);
        expect_bit(tx_allow, 1'b1, "R7 cts ignored when auto-CTS off");
        cts_n = 1'b0; step(3);
    endtask

    task automatic t_cts_on();
        auto_cts_en = 1'b1; step(3);
        expect_bit(tx_allow, 1'b1, "R8 allowed with cts low");
        cts_n = 1'b1; step(2);
        expect_bit(tx_allow, 1'b1, "R8 sync latency not yet elapsed");
        step(1);
        expect_bit(tx_allow, 1'b0, "R8 held three clocks after cts high");
        cts_n = 1'b0; step(3);
        expect_bit(tx_allow, 1'b1, "R8 resumed three clocks after cts low");
    endtask

    task automatic t_midchar();
        pulse_start();
        expect_bit(tx_allow, 1'b0, "R9 busy during character");
        cts_n = 1'b1; step(4);
        expect_bit(tx_allow, 1'b0, "R9 still busy with cts high");
        cts_n = 1'b0; step(4);
        expect_bit(tx_allow, 1'b0, "R9 character not ended by cts low");
        cts_n = 1'b1; step(4);
        pulse_done();
        expect_bit(tx_allow, 1'b0, "R9 next start held after done");
        cts_n = 1'b0; step(3);
        expect_bit(tx_allow, 1'b1, "R9 released after cts low");
        pulse_start(); step(2);
        pulse_done();
        expect_bit(tx_allow, 1'b1, "R9 ready after done with cts low");
    endtask

    task automatic t_release();
        cts_n = 1'b1; step(3);
        expect_bit(tx_allow, 1'b0, "R10 held before disable");
        auto_cts_en = 1'b0; #1;
        expect_bit(tx_allow, 1'b1, "R10 released in same cycle");
        step(1);
        expect_bit(tx_allow, 1'b1, "R10 stays released");
        cts_n = 1'b0; step(3);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_gpo();
        t_hyst(2'd0, 1, 4, 0);
        t_hyst(2'd1, 4, 8, 0);
        t_hyst(2'd2, 8, 14, 3);
        t_hyst(2'd3, 14, 16, 7);
        t_gate();
        t_cts_off();
        t_cts_on();
        t_midchar();
        t_release();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule